// File: doc/BRIEF.md
# Shared-Exponent RGB Decoder

This block turns one packed 32-bit colour word into four single-precision floating-point values (red, green, blue and alpha). The word carries three unsigned 9-bit channel integers and a single 5-bit scale code that applies to all three. Each channel is the integer times a power of two set by the scale code. The integers have no hidden leading one, no sign and no reserved codes. Every output is therefore a small integer-to-float conversion: a leading-zero count, a left-justified fraction and an exponent built from the scale code and the bit position of the leading one.

A word is presented with `in_valid`. One clock later the three colour floats, a constant alpha of 1.0 and `out_valid` appear on registered outputs. A cycle without `in_valid` leaves the float outputs as they were. The result is always exact, because nine significant bits fit in the 23-bit fraction without rounding.

Top module: `shared_exp_rgb_decoder`

## Requirements
- R1: The red integer is taken from `in_word[8:0]`, green from `in_word[17:9]`, blue from `in_word[26:18]`, and the 5-bit scale code `e` from `in_word[31:27]`.
- R2: Each colour output holds the IEEE-754 single-precision bit pattern of exactly m × 2^(e − 24), where m is that channel's integer.
- R3: A channel integer of zero gives 32'h0000_0000 on that output, whatever the scale code.
- R4: Scale code 31 behaves as an ordinary scale: with m = 511 the output equals 511 × 2^7 (32'h477F_8000), and no infinity or NaN is produced.
- R5: `out_a` equals 32'h3F80_0000 (1.0) whenever `out_valid` is high.
- R6: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R7: While `rst_n` is low at a clock edge, all four float outputs are cleared to zero and `out_valid` is cleared.
- R8: A cycle with `in_valid` low leaves `out_r`, `out_g`, `out_b` and `out_a` unchanged, whatever is on `in_word`.
- R9: Every colour output has its sign bit (bit 31) at 0, and its exponent field (bits 30:23) is never 8'hFF.
- R10: Words on consecutive cycles are accepted back to back, and each result appears exactly one cycle after its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 32 | Packed colour word: three 9-bit integers and a 5-bit shared scale code |
| out_valid | output | 1 | The float outputs carry a new result |
| out_r | output | 32 | Red channel, single-precision bit pattern |
| out_g | output | 32 | Green channel, single-precision bit pattern |
| out_b | output | 32 | Blue channel, single-precision bit pattern |
| out_a | output | 32 | Alpha channel, 1.0 after the first result |

## Verification
All results from a word are due on the first rising edge after the edge that samples it, one register stage away. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs against values it derives from a real-number model of m × 2^(e − 24). In streaming runs it checks the previous word's result before driving the next word, so each comparison falls exactly one cycle after its stimulus. The hold checks drive a changed word with `in_valid` low and compare one falling edge later. The reset checks sample while reset is still asserted, after a rising edge has passed.

// File: rtl/se_rgb_pkg.sv
// Package: shared constants for the shared-exponent RGB decoder.
// Assumes single-precision outputs (8-bit exponent, 23-bit fraction).
package se_rgb_pkg;

    // Single-precision field geometry
    localparam int FP_W      = 32;
    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;
    localparam int FP_BIAS   = 127;

    // Bit pattern of +1.0, used for the constant alpha channel
    localparam logic [FP_W-1:0] FP_ONE = 32'h3F80_0000;

    // Number of colour channels in a packed word
    localparam int NUM_CH = 3;

endpackage

// File: rtl/se_lzc.sv
// Module: leading-zero counter for a W-bit unsigned value.
// Gives the number of zeros above the most significant one, plus a flag
// for an all-zero input (the count then equals W).
// Assumes W >= 2. Purely combinational.
module se_lzc #(
    parameter int W = 9,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     value,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);

    // Scan upward from the LSB; the highest set bit assigns last and wins
    always_comb begin
        count   = CNT_W'(W);
        is_zero = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (value[i]) begin
                count   = CNT_W'(W - 1 - i);
                is_zero = 1'b0;
            end
        end
    end

endmodule

// File: rtl/se_chan_cvt.sv
// Module: converts one unsigned channel integer and a shared scale code
// into a single-precision bit pattern equal to mant * 2^(sexp - BIAS - MANT_W).
// Assumes the result is always a normal float (true for the default
// widths) and MANT_W - 1 <= 23, so the conversion never rounds.
// Purely combinational.
module se_chan_cvt
    import se_rgb_pkg::*;
#(
    parameter int MANT_W   = 9,
    parameter int EXP_W    = 5,
    parameter int EXP_BIAS = 15,
    localparam int LZ_W    = $clog2(MANT_W + 1),
    // Float exponent of a value whose leading one sits at the MSB of the
    // integer while the scale code is zero: FP_BIAS - EXP_BIAS - MANT_W + (MANT_W - 1)
    localparam int EXP_OFS = FP_BIAS - EXP_BIAS - 1,
    localparam int PAD_W   = FP_FRAC_W - (MANT_W - 1)
) (
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  sexp,
    output logic [FP_W-1:0]   fp
);

    logic [LZ_W-1:0]      lz;
    logic                 mant_zero;
    logic [MANT_W-1:0]    norm;
    logic [FP_EXP_W-1:0]  fexp;
    logic [FP_FRAC_W-1:0] frac;

    // Locate the leading one of the channel integer
    se_lzc #(
        .W (MANT_W)
    ) u_lzc (
        .value   (mant),
        .count   (lz),
        .is_zero (mant_zero)
    );

    // Left-justify the integer so the leading one reaches the MSB
    always_comb begin
        norm = mant << lz;
    end

    // Build the biased exponent from the scale code and leading-one position
    always_comb begin
        fexp = FP_EXP_W'(EXP_OFS) + FP_EXP_W'(sexp) - FP_EXP_W'(lz);
    end

    // Drop the now-implicit leading one and pad the fraction on the right
    always_comb begin
        frac = {norm[MANT_W-2:0], {PAD_W{1'b0}}};
    end

    // Assemble the float; zero integer (no leading one) yields +0.0
    always_comb begin
        if (mant_zero || !norm[MANT_W-1]) begin
            fp = '0;
        end else begin
            fp = {1'b0, fexp, frac};
        end
    end

endmodule

// File: rtl/se_field_split.sv
// Module: separates a packed shared-exponent word into its channel
// integers and the common scale code. Channel k occupies bits
// [k*MANT_W +: MANT_W]; the scale code sits above all channels.
// Purely combinational.
module se_field_split
    import se_rgb_pkg::*;
#(
    parameter int MANT_W = 9,
    parameter int EXP_W  = 5,
    localparam int WORD_W = NUM_CH * MANT_W + EXP_W
) (
    input  logic [WORD_W-1:0]             word,
    output logic [NUM_CH-1:0][MANT_W-1:0] mants,
    output logic [EXP_W-1:0]              sexp
);

    // One slice per channel, lowest channel in the lowest bits
    for (genvar k = 0; k < NUM_CH; k++) begin : g_slice
        always_comb begin
            mants[k] = word[k*MANT_W +: MANT_W];
        end
    end

    // Scale code shared by every channel
    always_comb begin
        sexp = word[WORD_W-1 -: EXP_W];
    end

endmodule

// File: rtl/shared_exp_rgb_decoder.sv
// Module: top of the shared-exponent RGB decoder. Splits the packed word,
// converts each channel to single precision in parallel and registers the
// four results with a one-cycle valid.
// Assumes synchronous active-low reset; default widths give a 32-bit word.
module shared_exp_rgb_decoder
    import se_rgb_pkg::*;
#(
    parameter int MANT_W   = 9,
    parameter int EXP_W    = 5,
    parameter int EXP_BIAS = 15,
    localparam int WORD_W  = NUM_CH * MANT_W + EXP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [FP_W-1:0]   out_r,
    output logic [FP_W-1:0]   out_g,
    output logic [FP_W-1:0]   out_b,
    output logic [FP_W-1:0]   out_a
);

    logic [NUM_CH-1:0][MANT_W-1:0] mants;
    logic [EXP_W-1:0]              sexp;
    logic [NUM_CH-1:0][FP_W-1:0]   fp_next;
    logic [NUM_CH-1:0][FP_W-1:0]   fp_q;
    logic [FP_W-1:0]               alpha_q;
    logic                          valid_q;

    // Field extraction
    se_field_split #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) u_split (
        .word  (in_word),
        .mants (mants),
        .sexp  (sexp)
    );

    // One converter per colour channel
    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        se_chan_cvt #(
            .MANT_W   (MANT_W),
            .EXP_W    (EXP_W),
            .EXP_BIAS (EXP_BIAS)
        ) u_cvt (
            .mant (mants[k]),
            .sexp (sexp),
            .fp   (fp_next[k])
        );
    end

    // Valid pipeline: one cycle from input to output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
        end
    end

    // Result registers load only on an accepted word and hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_q    <= '0;
            alpha_q <= '0;
        end else if (in_valid) begin
            fp_q    <= fp_next;
            alpha_q <= FP_ONE;
        end
    end

    // Drive the ports
    always_comb begin
        out_valid = valid_q;
        out_r     = fp_q[0];
        out_g     = fp_q[1];
        out_b     = fp_q[2];
        out_a     = alpha_q;
    end

endmodule

// File: rtl/se_rgb_checker.sv
// Module: assertion checker for shared_exp_rgb_decoder, bound to the top.
// Observes ports only.
module se_rgb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [26:0] in_mants,
    input logic        out_valid,
    input logic [31:0] out_r,
    input logic [31:0] out_g,
    input logic [31:0] out_b,
    input logic [31:0] out_a
);

    // R6: accepted word gives a valid result next cycle
    p_valid_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6: idle cycle gives no result next cycle
    p_idle_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: alpha is one with every result
    p_alpha_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_a == 32'h3F80_0000));

    // R9: no sign bit on any colour
    p_sign_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_r[31] && !out_g[31] && !out_b[31]));

    // R9: no infinity or NaN exponent field
    p_no_special_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_r[30:23] != 8'hFF && out_g[30:23] != 8'hFF
                       && out_b[30:23] != 8'hFF));

    // R3: zero red integer gives +0.0
    p_zero_red_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mants[8:0] == 9'd0) |=> (out_r == 32'd0));

    // R3: zero green integer gives +0.0
    p_zero_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mants[17:9] == 9'd0) |=> (out_g == 32'd0));

    // R3: zero blue integer gives +0.0
    p_zero_blue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mants[26:18] == 9'd0) |=> (out_b == 32'd0));

    // R8: idle cycle holds every float output
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)
                       && $stable(out_a)));

endmodule

bind shared_exp_rgb_decoder se_rgb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mants  (in_word[26:0]),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b),
    .out_a     (out_a)
);

// File: tb/shared_exp_rgb_decoder_tb.sv
module shared_exp_rgb_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [31:0] out_r, out_g, out_b, out_a;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    shared_exp_rgb_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_r     (out_r),
        .out_g     (out_g),
        .out_b     (out_b),
        .out_a     (out_a)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Reference: m * 2^(e-24) via real arithmetic, repacked to single precision
    function automatic logic [31:0] ref_fp(int m, int e);
        real v;
        logic [63:0] d;
        int fe;
        if (m == 0) return 32'd0;
        v = m;
        for (int k = 0; k < 24; k++) v = v / 2.0;
        for (int k = 0; k < e; k++)  v = v * 2.0;
        d  = $realtobits(v);
        fe = int'(d[62:52]) - 1023 + 127;
        return {1'b0, fe[7:0], d[51:29]};
    endfunction

    function automatic logic [31:0] pack(int r, int g, int b, int e);
        return {e[4:0], b[8:0], g[8:0], r[8:0]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against word w (already captured)
    task automatic chk_word(string req, logic [31:0] w);
        chk(req, "valid", {31'd0, out_valid}, 32'd1);
        chk(req, "red",   out_r, ref_fp(int'(w[8:0]),   int'(w[31:27])));
        chk(req, "green", out_g, ref_fp(int'(w[17:9]),  int'(w[31:27])));
        chk(req, "blue",  out_b, ref_fp(int'(w[26:18]), int'(w[31:27])));
        chk("R5", "alpha", out_a, 32'h3F80_0000);
    endtask

    // Single word: drive at falling edge, check one cycle later
    task automatic send(string req, logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        chk_word(req, w);
    endtask

    initial begin
        logic [31:0] prev;
        logic [31:0] cur;
        void'($urandom(32'd4242));

        // R7: reset clears outputs even with a valid word present
        in_valid = 1'b1;
        in_word  = pack(511, 511, 511, 20);
        repeat (3) @(negedge clk);
        chk("R7", "valid", {31'd0, out_valid}, 32'd0);
        chk("R7", "red",   out_r, 32'd0);
        chk("R7", "green", out_g, 32'd0);
        chk("R7", "blue",  out_b, 32'd0);
        chk("R7", "alpha", out_a, 32'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        // R1: distinct integers per field
        send("R1", pack(1, 2, 4, 24));
        chk("R1", "red literal",   out_r, 32'h3F80_0000);
        chk("R1", "green literal", out_g, 32'h4000_0000);
        chk("R1", "blue literal",  out_b, 32'h4080_0000);
        send("R1", pack(3, 0, 0, 15));
        send("R1", pack(0, 5, 0, 15));
        send("R1", pack(0, 0, 7, 15));

        // R3: zero integers at extreme scale codes
        send("R3", pack(0, 0, 0, 31));
        send("R3", pack(0, 0, 0, 0));
        send("R3", pack(0, 300, 0, 9));

        // R4: scale code 31 as ordinary scale
        send("R4", pack(511, 1, 256, 31));
        chk("R4", "red literal", out_r, 32'h477F_8000);

        // R2: smallest nonzero values and full-scale values
        send("R2", pack(1, 1, 1, 0));
        chk("R2", "red literal", out_r, 32'h3380_0000);
        send("R2", pack(511, 256, 255, 0));
        send("R2", pack(170, 341, 85, 17));

        // R8: idle cycle with a changed word leaves outputs unchanged
        send("R8", pack(100, 200, 300, 12));
        @(negedge clk);
        in_word = pack(7, 8, 9, 3);
        @(negedge clk);
        chk("R6", "idle valid", {31'd0, out_valid}, 32'd0);
        chk("R8", "red hold",   out_r, ref_fp(100, 12));
        chk("R8", "green hold", out_g, ref_fp(200, 12));
        chk("R8", "blue hold",  out_b, ref_fp(300, 12));
        chk("R8", "alpha hold", out_a, 32'h3F80_0000);

        // R10/R2/R9: random back-to-back stream
        prev = '0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk_word("R10", prev);
                chk("R9", "signs", {29'd0, out_r[31], out_g[31], out_b[31]}, 32'd0);
            end
            cur      = $urandom();
            if (i % 13 == 0) cur[8:0] = 9'd0;
            in_valid = 1'b1;
            in_word  = cur;
            prev     = cur;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk_word("R10", prev);

        // R6: valid drops after stream ends
        @(negedge clk);
        chk("R6", "valid low", {31'd0, out_valid}, 32'd0);

        // R2: random isolated words
        for (int i = 0; i < 100; i++) begin
            send("R2", $urandom());
        end

        done = 1'b1;
    end

    // Finish on completion or watchdog
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule